// File: doc/BRIEF.md
# Speculative Reorder Buffer with Commit

This block is the in-order completion queue of an out-of-order core. Each issued instruction takes one entry at the tail, and the index of that entry goes back to the issue logic as the rename tag. Execution units later broadcast results on a shared result bus tagged with that index. Each entry stores its kind (branch, store or register-writing operation), a destination, the result value, an exception flag with a code, a misprediction flag and a ready bit.

Retirement happens at the head, in program order, up to two entries per clock. A finished register operation drives a register-file write port. A finished store drives a memory store port. A correctly predicted branch leaves without writing anything. If the head entry is a mispredicted branch, or it carries an exception, the block raises a flush pulse and throws away every entry still held. The head index is kept, so the next instruction issued reuses it. Consumers can also look up a tag and read a value that is finished but not yet retired.

Top module: `spec_rob`

## Requirements
- R1: After a synchronous active-low reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, and no write, store, flush or lookup hit is driven.
- R2: Each accepted allocation returns as its tag the next index modulo DEPTH, counted from the current head. Once DEPTH entries are held, `alloc_ready` is 0.
- R3: A result whose tag matches a held entry sets that entry's value and marks it ready from the next cycle. A lookup of that tag then hits with the value until the entry retires. A lookup of a tag with no result, or of a retired tag, misses.
- R4: Only the head may retire, and only once it is ready. A younger entry that is ready waits while the head is not ready.
- R5: Kind encoding is 0 for a branch, 1 for a store and 2 for a register operation. A retiring register operation asserts its `rf_we` bit and drives the low REG_W bits of its destination with its value. A retiring store asserts its `st_we` bit and drives its destination as the address with its value as the data. A retiring branch drives neither port.
- R6: Two entries may retire in one clock, on slot 0 (bit 0 and the low field) and slot 1. Slot 1 retires only when slot 0 also retires, and never when slot 1's entry is a mispredicted branch or carries an exception.
- R7: A ready head that is a mispredicted branch raises `flush_valid` for one cycle with `flush_exc` 0 and drives no write. Every entry is discarded. The next allocation reuses the head index.
- R8: A ready head that carries an exception raises `flush_valid` with `flush_exc` 1 and its code on `flush_code`, and writes nothing for that entry.
- R9: An exception recorded in an entry younger than a mispredicted head branch is discarded by that branch's flush and never raises a flush of its own.
- R10: Allocation and retirement may occur in the same clock. `alloc_ready` is held at 0 during a flush cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Request a new entry |
| alloc_kind | input | 2 | Kind: 0 branch, 1 store, 2 register |
| alloc_dest | input | ADDR_W | Register number or store address |
| alloc_ready | output | 1 | An entry can be taken this cycle |
| alloc_tag | output | TAG_W | Index given to the request |
| res_valid | input | 1 | Result bus carries a result |
| res_tag | input | TAG_W | Entry the result belongs to |
| res_value | input | DATA_W | Result value or store data |
| res_exc | input | 1 | The instruction raised an exception |
| res_code | input | CODE_W | Exception code |
| res_mispred | input | 1 | The branch was mispredicted |
| look_tag | input | TAG_W | Tag to look up |
| look_hit | output | 1 | Tag is held and ready |
| look_value | output | DATA_W | Value of the looked-up entry |
| rf_we | output | 2 | Register write strobe per retire slot |
| rf_waddr | output | 2*REG_W | Register numbers, slot 0 in the low field |
| rf_wdata | output | 2*DATA_W | Register data, slot 0 in the low field |
| st_we | output | 2 | Store strobe per retire slot |
| st_addr | output | 2*ADDR_W | Store addresses, slot 0 in the low field |
| st_data | output | 2*DATA_W | Store data, slot 0 in the low field |
| flush_valid | output | 1 | All held entries are discarded |
| flush_exc | output | 1 | Flush caused by an exception |
| flush_code | output | CODE_W | Exception code of the flushing entry |

## Verification
Retirement at the head can coincide with either a new allocation at the tail or a flush decision. The bench sets up both collisions deliberately. In the first, it posts the head's result while the buffer holds DEPTH-1 entries and issues in that same clock. It then checks that the returned tag is the index just freed and that `alloc_ready` goes low only after one more allocation. In the second, a ready register entry sits ahead of a ready mispredicted branch. The bench checks that only slot 0 writes in that clock and that the flush follows one clock later. Across all of this, the rounds move the head through every index, so the tags, addresses and data expected at each port are computed from the round number.

// File: rtl/rob_pkg.sv
// Shared definitions for the speculative reorder buffer.
// Assumes: kind codes are fixed because issue logic drives them directly.
package rob_pkg;
    typedef enum logic [1:0] {
        KIND_BR  = 2'd0,
        KIND_ST  = 2'd1,
        KIND_REG = 2'd2
    } rob_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
// Head/tail/occupancy tracker for the circular buffer.
// Assumes: DEPTH is a power of two so pointers wrap naturally; retire_n is
// zero whenever flush is set.
module rob_ptrs #(
    parameter int DEPTH = 8,
    parameter int TAG_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire,
    input  logic [1:0]       retire_n,
    input  logic             flush,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic [CNT_W-1:0] count
);
    // Advance pointers on retire/allocate; a flush collapses tail onto head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (flush) begin
            tail  <= head;
            count <= '0;
        end else begin
            head  <= head + TAG_W'(retire_n);
            tail  <= tail + TAG_W'(alloc_fire);
            count <= count + CNT_W'(alloc_fire) - CNT_W'(retire_n);
        end
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R2
    no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |-> count < CNT_W'(DEPTH));
    // R4
    retire_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(retire_n) <= count);
    // R7
    ptr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        TAG_W'(tail - head) == count[TAG_W-1:0]);
endmodule

// File: rtl/rob_store.sv
// Entry storage: allocation writes, result-bus capture, lookup by tag, and
// a view of the two oldest entries for the retire logic.
// Assumes: alloc_fire is never set in a flush cycle or when full.
module rob_store
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int CODE_W = 4,
    parameter int TAG_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_fire,
    input  logic [TAG_W-1:0]  alloc_idx,
    input  rob_kind_e         alloc_kind,
    input  logic [ADDR_W-1:0] alloc_dest,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_value,
    input  logic              res_exc,
    input  logic [CODE_W-1:0] res_code,
    input  logic              res_mispred,
    input  logic [TAG_W-1:0]  head,
    input  logic [1:0]        retire_n,
    input  logic              flush,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_value,
    output logic              h_valid [2],
    output logic              h_ready [2],
    output rob_kind_e         h_kind  [2],
    output logic [ADDR_W-1:0] h_dest  [2],
    output logic [DATA_W-1:0] h_value [2],
    output logic              h_exc   [2],
    output logic              h_mis   [2],
    output logic [CODE_W-1:0] h_code  [2]
);
    logic [DEPTH-1:0]  valid_q;
    logic [DEPTH-1:0]  ready_q;
    rob_kind_e         kind_q  [DEPTH];
    logic [ADDR_W-1:0] dest_q  [DEPTH];
    logic [DATA_W-1:0] value_q [DEPTH];
    logic              exc_q   [DEPTH];
    logic              mis_q   [DEPTH];
    logic [CODE_W-1:0] code_q  [DEPTH];
    logic [TAG_W-1:0]  slot_idx [2];
    logic              capture;

    assign capture = res_valid && valid_q[res_tag] && !flush;

    // Index of the two oldest entries and their contents for retirement.
    generate
        for (genvar s = 0; s < 2; s++) begin : g_view
            assign slot_idx[s] = head + TAG_W'(s);
            assign h_valid[s]  = valid_q[slot_idx[s]];
            assign h_ready[s]  = ready_q[slot_idx[s]];
            assign h_kind[s]   = kind_q[slot_idx[s]];
            assign h_dest[s]   = dest_q[slot_idx[s]];
            assign h_value[s]  = value_q[slot_idx[s]];
            assign h_exc[s]    = exc_q[slot_idx[s]];
            assign h_mis[s]    = mis_q[slot_idx[s]];
            assign h_code[s]   = code_q[slot_idx[s]];
        end
    endgenerate

    // Operand lookup: finished but unretired values only.
    assign look_hit   = valid_q[look_tag] && ready_q[look_tag];
    assign look_value = value_q[look_tag];

    // Occupancy and completion flags per entry.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= '0;
            ready_q <= '0;
        end else begin
            for (int s = 0; s < 2; s++) begin
                if (s < int'(retire_n)) valid_q[slot_idx[s]] <= 1'b0;
            end
            if (alloc_fire) begin
                valid_q[alloc_idx] <= 1'b1;
                ready_q[alloc_idx] <= 1'b0;
            end
            if (capture) ready_q[res_tag] <= 1'b1;
        end
    end

    // Entry payload: descriptor at allocation, outcome at result capture.
    always_ff @(posedge clk) begin
        if (alloc_fire) begin
            kind_q[alloc_idx] <= alloc_kind;
            dest_q[alloc_idx] <= alloc_dest;
            exc_q[alloc_idx]  <= 1'b0;
            mis_q[alloc_idx]  <= 1'b0;
            code_q[alloc_idx] <= '0;
        end
        if (capture) begin
            value_q[res_tag] <= res_value;
            exc_q[res_tag]   <= res_exc;
            mis_q[res_tag]   <= res_mispred;
            code_q[res_tag]  <= res_code;
        end
    end

    // R3
    capture_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> ready_q[$past(res_tag)]);
    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
endmodule

// File: rtl/rob_retire.sv
// Retire decision for the two oldest entries: in-order commit, port drive,
// and flush on a mispredicted branch or an exception at the head.
// Assumes: h_* reflect the entries at head and head+1.
module rob_retire
    import rob_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int REG_W  = 5,
    parameter int CODE_W = 4
) (
    input  logic              h_valid [2],
    input  logic              h_ready [2],
    input  rob_kind_e         h_kind  [2],
    input  logic [ADDR_W-1:0] h_dest  [2],
    input  logic [DATA_W-1:0] h_value [2],
    input  logic              h_exc   [2],
    input  logic              h_mis   [2],
    input  logic [CODE_W-1:0] h_code  [2],
    output logic [1:0]        retire_n,
    output logic              flush,
    output logic              flush_exc,
    output logic [CODE_W-1:0] flush_code,
    output logic [1:0]        rf_we,
    output logic [1:0][REG_W-1:0]  rf_waddr,
    output logic [1:0][DATA_W-1:0] rf_wdata,
    output logic [1:0]        st_we,
    output logic [1:0][ADDR_W-1:0] st_addr,
    output logic [1:0][DATA_W-1:0] st_data
);
    logic [1:0] done;
    logic [1:0] stop;
    logic [1:0] go;

    // Per-slot readiness and whether the entry must end speculation.
    always_comb begin
        for (int s = 0; s < 2; s++) begin
            done[s] = h_valid[s] && h_ready[s];
            stop[s] = h_exc[s] || (h_kind[s] == KIND_BR && h_mis[s]);
        end
    end

    // Slot 1 follows slot 0 and never ends speculation itself.
    assign go[0]      = done[0] && !stop[0];
    assign go[1]      = go[0] && done[1] && !stop[1];
    assign flush      = done[0] && stop[0];
    assign flush_exc  = flush && h_exc[0];
    assign flush_code = flush_exc ? h_code[0] : '0;
    assign retire_n   = go[1] ? 2'd2 : (go[0] ? 2'd1 : 2'd0);

    // Drive the register and store ports for each retiring slot.
    always_comb begin
        for (int s = 0; s < 2; s++) begin
            rf_we[s]    = go[s] && (h_kind[s] == KIND_REG);
            rf_waddr[s] = h_dest[s][REG_W-1:0];
            rf_wdata[s] = h_value[s];
            st_we[s]    = go[s] && (h_kind[s] == KIND_ST);
            st_addr[s]  = h_dest[s];
            st_data[s]  = h_value[s];
        end
    end

    // R4
    head_ready_chk: assert final ((rf_we == 2'b00 && st_we == 2'b00) || done[0]);
    // R8
    flush_nowrite_chk: assert final (!flush || (rf_we == 2'b00 && st_we == 2'b00));
endmodule

// File: rtl/spec_rob.sv
// Speculative reorder buffer top: allocation at the tail, result capture,
// lookup, two-wide in-order retire, and flush on misprediction/exception.
// Assumes: DEPTH is a power of two and at least 2.
module spec_rob
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int REG_W  = 5,
    parameter int CODE_W = 4,
    parameter int TAG_W  = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_req,
    input  logic [1:0]            alloc_kind,
    input  logic [ADDR_W-1:0]     alloc_dest,
    output logic                  alloc_ready,
    output logic [TAG_W-1:0]      alloc_tag,
    input  logic                  res_valid,
    input  logic [TAG_W-1:0]      res_tag,
    input  logic [DATA_W-1:0]     res_value,
    input  logic                  res_exc,
    input  logic [CODE_W-1:0]     res_code,
    input  logic                  res_mispred,
    input  logic [TAG_W-1:0]      look_tag,
    output logic                  look_hit,
    output logic [DATA_W-1:0]     look_value,
    output logic [1:0]            rf_we,
    output logic [2*REG_W-1:0]    rf_waddr,
    output logic [2*DATA_W-1:0]   rf_wdata,
    output logic [1:0]            st_we,
    output logic [2*ADDR_W-1:0]   st_addr,
    output logic [2*DATA_W-1:0]   st_data,
    output logic                  flush_valid,
    output logic                  flush_exc,
    output logic [CODE_W-1:0]     flush_code
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [TAG_W-1:0]  head;
    logic [TAG_W-1:0]  tail;
    logic [CNT_W-1:0]  count;
    logic [1:0]        retire_n;
    logic              flush;
    logic              alloc_fire;
    logic              h_valid [2];
    logic              h_ready [2];
    rob_kind_e         h_kind  [2];
    logic [ADDR_W-1:0] h_dest  [2];
    logic [DATA_W-1:0] h_value [2];
    logic              h_exc   [2];
    logic              h_mis   [2];
    logic [CODE_W-1:0] h_code  [2];
    logic [1:0][REG_W-1:0]  rf_waddr_s;
    logic [1:0][DATA_W-1:0] rf_wdata_s;
    logic [1:0][ADDR_W-1:0] st_addr_s;
    logic [1:0][DATA_W-1:0] st_data_s;

    // Issue handshake: stall when full or while the buffer is being flushed.
    assign alloc_ready = (count != CNT_W'(DEPTH)) && !flush;
    assign alloc_fire  = alloc_req && alloc_ready;
    assign alloc_tag   = tail;
    assign flush_valid = flush;
    assign rf_waddr    = rf_waddr_s;
    assign rf_wdata    = rf_wdata_s;
    assign st_addr     = st_addr_s;
    assign st_data     = st_data_s;

    rob_ptrs #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire),
        .retire_n(retire_n), .flush(flush),
        .head(head), .tail(tail), .count(count)
    );

    rob_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                .CODE_W(CODE_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .alloc_fire(alloc_fire), .alloc_idx(tail),
        .alloc_kind(rob_kind_e'(alloc_kind)), .alloc_dest(alloc_dest),
        .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
        .res_exc(res_exc), .res_code(res_code), .res_mispred(res_mispred),
        .head(head), .retire_n(retire_n), .flush(flush),
        .look_tag(look_tag), .look_hit(look_hit), .look_value(look_value),
        .h_valid(h_valid), .h_ready(h_ready), .h_kind(h_kind),
        .h_dest(h_dest), .h_value(h_value), .h_exc(h_exc),
        .h_mis(h_mis), .h_code(h_code)
    );

    rob_retire #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W),
                 .CODE_W(CODE_W)) u_retire (
        .h_valid(h_valid), .h_ready(h_ready), .h_kind(h_kind),
        .h_dest(h_dest), .h_value(h_value), .h_exc(h_exc),
        .h_mis(h_mis), .h_code(h_code),
        .retire_n(retire_n), .flush(flush), .flush_exc(flush_exc),
        .flush_code(flush_code),
        .rf_we(rf_we), .rf_waddr(rf_waddr_s), .rf_wdata(rf_wdata_s),
        .st_we(st_we), .st_addr(st_addr_s), .st_data(st_data_s)
    );

    // R7
    flush_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (alloc_ready && !flush_valid && alloc_tag == $past(alloc_tag) - TAG_W'($past(count))));
    // R10
    flush_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> !alloc_ready);
endmodule

// File: tb/spec_rob_bench.sv
// Self-checking bench for spec_rob: rotating retire rounds, fill/stall,
// same-cycle allocate+retire, exception flush and mispredict flush.
module spec_rob_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_req = 1'b0;
    logic [1:0]  alloc_kind = 2'd0;
    logic [15:0] alloc_dest = '0;
    logic        alloc_ready;
    logic [2:0]  alloc_tag;
    logic        res_valid = 1'b0;
    logic [2:0]  res_tag = '0;
    logic [31:0] res_value = '0;
    logic        res_exc = 1'b0;
    logic [3:0]  res_code = '0;
    logic        res_mispred = 1'b0;
    logic [2:0]  look_tag = '0;
    logic        look_hit;
    logic [31:0] look_value;
    logic [1:0]  rf_we;
    logic [9:0]  rf_waddr;
    logic [63:0] rf_wdata;
    logic [1:0]  st_we;
    logic [31:0] st_addr;
    logic [63:0] st_data;
    logic        flush_valid;
    logic        flush_exc;
    logic [3:0]  flush_code;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    spec_rob u_spec_rob (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
        .res_exc(res_exc), .res_code(res_code), .res_mispred(res_mispred),
        .look_tag(look_tag), .look_hit(look_hit), .look_value(look_value),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .st_we(st_we), .st_addr(st_addr), .st_data(st_data),
        .flush_valid(flush_valid), .flush_exc(flush_exc), .flush_code(flush_code)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // All operations start and end just after a falling edge.
    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic alloc(input logic [1:0] kind, input logic [15:0] dest,
                         output logic [2:0] tag);
        tag = alloc_tag;
        alloc_req = 1'b1; alloc_kind = kind; alloc_dest = dest;
        @(posedge clk); #1;
        alloc_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic result(input logic [2:0] tag, input logic [31:0] val,
                          input logic exc, input logic [3:0] code, input logic mis);
        res_valid = 1'b1; res_tag = tag; res_value = val;
        res_exc = exc; res_code = code; res_mispred = mis;
        @(posedge clk); #1;
        res_valid = 1'b0; res_exc = 1'b0; res_mispred = 1'b0;
        @(negedge clk);
    endtask

    task automatic look(input logic [2:0] tag);
        look_tag = tag; #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [2:0] hd;
        logic [2:0] t0, t1, t2, tx;
        hd = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        look(3'd0);
        chk("R1", "alloc_ready", alloc_ready, 1);
        chk("R1", "alloc_tag", alloc_tag, 0);
        chk("R1", "writes", {rf_we, st_we, flush_valid}, 0);
        chk("R1", "look_hit", look_hit, 0);

        // Rotating rounds: head passes every index
        for (int r = 0; r < 8; r++) begin
            alloc(2'd2, 16'(r + 1), t0);
            alloc(2'd1, 16'h0100 + 16'(r), t1);
            alloc(2'd0, 16'h0, t2);
            chk("R2", "tag0", t0, hd);
            chk("R2", "tag1", t1, 3'(hd + 3'd1));
            chk("R2", "tag2", t2, 3'(hd + 3'd2));
            result(t2, 32'h0, 1'b0, 4'h0, 1'b0);
            result(t1, 32'h5000 + 32'(r), 1'b0, 4'h0, 1'b0);
            // R4 younger ready entries wait behind a head without result
            chk("R4", "no retire", {rf_we, st_we, flush_valid}, 0);
            look(t1);
            chk("R3", "hit t1", look_hit, 1);
            chk("R3", "value t1", look_value, 32'h5000 + 32'(r));
            look(t0);
            chk("R3", "miss t0", look_hit, 0);
            result(t0, 32'h7000 + 32'(r * 3), 1'b0, 4'h0, 1'b0);
            look(t0);
            chk("R3", "hit t0", look_hit, 1);
            // R5 R6 register on slot 0, store on slot 1
            chk("R6", "rf_we", rf_we, 2'b01);
            chk("R6", "st_we", st_we, 2'b10);
            chk("R5", "rf_waddr0", rf_waddr[4:0], 5'(r + 1));
            chk("R5", "rf_wdata0", rf_wdata[31:0], 32'h7000 + 32'(r * 3));
            chk("R5", "st_addr1", st_addr[31:16], 16'h0100 + 16'(r));
            chk("R5", "st_data1", st_data[63:32], 32'h5000 + 32'(r));
            step();
            // R5 branch retires without writing
            chk("R5", "branch silent", {rf_we, st_we, flush_valid}, 0);
            look(t0);
            chk("R3", "retired miss", look_hit, 0);
            step();
            hd = 3'(hd + 3'd3);
        end

        // Fill to capacity
        for (int i = 0; i < 8; i++) begin
            alloc(2'd2, 16'(i), tx);
            chk("R2", "fill tag", tx, 3'(hd + 3'(i)));
        end
        chk("R2", "full stall", alloc_ready, 0);
        result(hd, 32'h11, 1'b0, 4'h0, 1'b0);
        chk("R4", "single retire", rf_we, 2'b01);
        chk("R4", "retire data", rf_wdata[31:0], 32'h11);
        step();
        hd = 3'(hd + 3'd1);
        // R10 allocate in the clock that retires the head
        result(hd, 32'h22, 1'b0, 4'h0, 1'b0);
        chk("R10", "retire visible", rf_we, 2'b01);
        chk("R10", "ready at 7", alloc_ready, 1);
        alloc(2'd2, 16'd9, tx);
        chk("R10", "reused tag", tx, 3'(hd - 3'd1));
        chk("R10", "still room", alloc_ready, 1);
        hd = 3'(hd + 3'd1);
        alloc(2'd2, 16'd10, tx);
        chk("R10", "full again", alloc_ready, 0);

        // Exception at head
        result(hd, 32'h33, 1'b1, 4'hA, 1'b0);
        chk("R8", "flush", flush_valid, 1);
        chk("R8", "flush_exc", flush_exc, 1);
        chk("R8", "code", flush_code, 4'hA);
        chk("R8", "no write", {rf_we, st_we}, 0);
        chk("R10", "stall in flush", alloc_ready, 0);
        step();
        chk("R7", "flush pulse", flush_valid, 0);
        chk("R7", "empty ready", alloc_ready, 1);
        chk("R7", "tag at head", alloc_tag, hd);

        // Mispredict with a younger exception
        alloc(2'd0, 16'h0, t0);
        alloc(2'd2, 16'd3, t1);
        result(t1, 32'h44, 1'b1, 4'h3, 1'b0);
        look(t1);
        chk("R3", "exc value hit", look_hit, 1);
        result(t0, 32'h0, 1'b0, 4'h0, 1'b1);
        chk("R9", "flush", flush_valid, 1);
        chk("R9", "not exc", flush_exc, 0);
        chk("R7", "no write", {rf_we, st_we}, 0);
        step();
        chk("R9", "no second flush", flush_valid, 0);
        chk("R7", "tag reuse", alloc_tag, hd);
        look(t1);
        chk("R7", "discarded", look_hit, 0);

        // Slot 1 holds a mispredicted branch: slot 0 retires alone
        alloc(2'd2, 16'd7, t0);
        alloc(2'd0, 16'h0, t1);
        result(t1, 32'h0, 1'b0, 4'h0, 1'b1);
        result(t0, 32'h55, 1'b0, 4'h0, 1'b0);
        chk("R6", "slot0 only", rf_we, 2'b01);
        chk("R6", "waddr", rf_waddr[4:0], 5'd7);
        chk("R6", "no flush yet", flush_valid, 0);
        step();
        chk("R7", "flush next", flush_valid, 1);
        chk("R7", "mispredict kind", flush_exc, 0);
        step();
        hd = 3'(hd + 3'd1);
        chk("R7", "tag after", alloc_tag, hd);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule